// File: doc/BRIEF.md
# Fully Associative Write-Back Cache Controller

This block is a small data cache placed between a simple processor and a slow main memory. The processor issues one request at a time: a request strobe, a write enable, a 12-bit word address and 16-bit write data. The controller answers with 16-bit read data and a one-cycle ready pulse. It holds eight lines of four 16-bit words. Any line may hold any memory line, so every lookup compares the request tag against all eight stored tags at once.

On a miss, a rotating pointer picks the victim line. If the victim holds modified data, the whole 64-bit line is first written back to memory at the address given by its stored tag. The required line is then fetched in one 64-bit transfer. Writes allocate a line on a miss and mark it dirty.

Main memory runs at one eighth of the system clock, and its reads take one extra slow cycle. The controller generates its own divide-by-8 enable. It holds every memory address and strobe steady until a slow edge has taken it.

Top module: `assoc_cache`

## Requirements
- R1: The request address splits into a 10-bit tag (bits 11:2) and a 2-bit word offset (bits 1:0). Word k of a line occupies bits 16k+15:16k of the 64-bit memory word. The memory line address is the tag.
- R2: After reset, cpuReady, memRd and memWr are low and every line is invalid and clean. An invalid line never produces a hit, even when its stored tag equals the request tag.
- R3: A read hit returns the addressed word with cpuReady high after the second rising edge, counting the edge that accepts the request. A read hit issues no memory transaction.
- R4: A miss whose victim is clean performs exactly one memory read of the requested line and no memory write.
- R5: A miss whose victim is dirty first writes the victim's 64-bit contents to memory at the victim's stored tag. Only then is the requested line read.
- R6: The victim pointer starts at line 0, advances by one after every refill, and wraps from 7 to 0.
- R7: A write hit changes only the addressed word and marks the line dirty. A write miss refills the line first, then merges the word and marks the line dirty.
- R8: Memory slow edges fall on the 8th, 16th, 24th… rising clock edge after reset is released. memRd, memWr, memAddr and memWdata stay unchanged from the moment a strobe rises until a slow edge has sampled it.
- R9: Refill data is captured at the slow edge after the edge that sampled the read address. A refill clears the line's dirty bit and sets its valid bit.
- R10: cpuReady is high for exactly one clock per accepted request.
- R11: A request strobe raised while the controller is busy is ignored. It produces no ready pulse and does not change cached data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpuReq | input | 1 | Request strobe, taken only when idle |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 12 | Word address |
| cpuWdata | input | 16 | Write data |
| cpuRdata | output | 16 | Read data, valid with cpuReady |
| cpuReady | output | 1 | One-cycle completion pulse |
| memAddr | output | 10 | Memory line address |
| memWdata | output | 64 | Line written back to memory |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| memRdata | input | 64 | Line returned by memory |

## Verification
The risky overlap is a new request strobe arriving while a refill is still waiting on the slow memory edge. The bench provokes it by pulsing a write to the line being fetched a few cycles into the refill. It then requires exactly one ready pulse, and a later read of that word must return the memory value rather than the stray write data.

A second overlap is the write-back of a dirty victim followed by the read of a new line across consecutive slow edges. This is judged from the count of memory writes and reads in each transaction. It is also judged by reading back, after eviction, words written earlier.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WBACK,
    ST_RDADDR,
    ST_RDWAIT
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeReq;    // latch request fields
    logic hitUpdate;  // deliver/merge word on a hit
    logic fillLine;   // store refill line at victim slot
    logic wbSel;      // memory address comes from victim tag
  } ctlStrobes_t;

endpackage

// File: rtl/cache_slowtick.sv
module cache_slowtick #(
  parameter int MEM_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int DIV_W = $clog2(MEM_DIV);

  logic [DIV_W-1:0] divCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt <= '0;
    end else if (divCnt == DIV_W'(MEM_DIV - 1)) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  // high during the cycle whose closing edge is a slow-memory edge
  assign tick = (divCnt == DIV_W'(MEM_DIV - 1));

endmodule

// File: rtl/cache_datapath.sv
module cache_datapath
  import cache_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16,
  parameter int WORDS  = 4,
  parameter int LINES  = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  ctlStrobes_t                          ctl,
  input  logic                                 reqWe,
  input  logic [ADDR_W-1:0]                    reqAddr,
  input  logic [WORD_W-1:0]                    reqWdata,
  input  logic [WORD_W*WORDS-1:0]              memRdata,
  output logic                                 hit,
  output logic                                 victimDirty,
  output logic [ADDR_W-$clog2(WORDS)-1:0]      memAddr,
  output logic [WORD_W*WORDS-1:0]              memWdata,
  output logic [WORD_W-1:0]                    rspData
);
  localparam int OFFS_W = $clog2(WORDS);
  localparam int TAG_W  = ADDR_W - OFFS_W;
  localparam int IDX_W  = $clog2(LINES);
  localparam int LINE_W = WORD_W * WORDS;

  logic [ADDR_W-1:0] addrQ;
  logic              weQ;
  logic [WORD_W-1:0] wdataQ;
  logic [WORD_W-1:0] rspQ;

  logic [TAG_W-1:0]  tagMem  [LINES];
  logic [LINE_W-1:0] dataMem [LINES];
  logic [LINES-1:0]  validQ;
  logic [LINES-1:0]  dirtyQ;
  logic [IDX_W-1:0]  victimPtr;

  logic [TAG_W-1:0]  reqTag;
  logic [OFFS_W-1:0] reqOffs;
  logic [LINES-1:0]  matchVec;
  logic [IDX_W-1:0]  hitIdx;
  logic [WORD_W-1:0] hitWord;
  logic [LINE_W-1:0] mergedLine;

  assign reqTag  = addrQ[ADDR_W-1:OFFS_W];
  assign reqOffs = addrQ[OFFS_W-1:0];

  // parallel tag compare over every line
  for (genvar g = 0; g < LINES; g++) begin : gMatch
    assign matchVec[g] = validQ[g] && (tagMem[g] == reqTag);
  end

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (matchVec[i]) hitIdx = IDX_W'(i);
    end
  end

  assign hit         = |matchVec;
  assign victimDirty = validQ[victimPtr] && dirtyQ[victimPtr];
  assign hitWord     = dataMem[hitIdx][reqOffs*WORD_W +: WORD_W];

  always_comb begin
    mergedLine = dataMem[hitIdx];
    mergedLine[reqOffs*WORD_W +: WORD_W] = wdataQ;
  end

  assign memAddr  = ctl.wbSel ? tagMem[victimPtr] : reqTag;
  assign memWdata = dataMem[victimPtr];
  assign rspData  = rspQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ     <= '0;
      weQ       <= 1'b0;
      wdataQ    <= '0;
      rspQ      <= '0;
      validQ    <= '0;
      dirtyQ    <= '0;
      victimPtr <= '0;
      for (int i = 0; i < LINES; i++) tagMem[i] <= '0;
    end else begin
      if (ctl.takeReq) begin
        addrQ  <= reqAddr;
        weQ    <= reqWe;
        wdataQ <= reqWdata;
      end
      if (ctl.hitUpdate) begin
        rspQ <= weQ ? wdataQ : hitWord;
        if (weQ) dirtyQ[hitIdx] <= 1'b1;
      end
      if (ctl.fillLine) begin
        tagMem[victimPtr] <= reqTag;
        validQ[victimPtr] <= 1'b1;
        dirtyQ[victimPtr] <= 1'b0;
        victimPtr         <= victimPtr + IDX_W'(1);
      end
    end
  end

  // line storage carries no reset; valid bits guard it
  always_ff @(posedge clk) begin
    if (ctl.hitUpdate && weQ) dataMem[hitIdx] <= mergedLine;
    if (ctl.fillLine)         dataMem[victimPtr] <= memRdata;
  end

  a_r6_ptr_step: assert property (@(posedge clk) disable iff (rst)
    ctl.fillLine |=> victimPtr == $past(victimPtr) + IDX_W'(1));

  a_r9_fill_clean: assert property (@(posedge clk) disable iff (rst)
    ctl.fillLine |=> (validQ[$past(victimPtr)] && !dirtyQ[$past(victimPtr)]));

  a_r7_write_dirty: assert property (@(posedge clk) disable iff (rst)
    (ctl.hitUpdate && weQ) |=> dirtyQ[$past(hitIdx)]);

endmodule

// File: rtl/cache_control.sv
module cache_control
  import cache_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic        hit,
  input  logic        victimDirty,
  input  logic        tick,
  output ctlStrobes_t ctl,
  output logic        ready,
  output logic        memRd,
  output logic        memWr
);
  ctlState_t state, nextState;
  logic      readyQ;

  always_comb begin
    nextState = state;
    ctl       = '0;
    memRd     = 1'b0;
    memWr     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (req) begin
          ctl.takeReq = 1'b1;
          nextState   = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (hit) begin
          ctl.hitUpdate = 1'b1;
          nextState     = ST_IDLE;
        end else if (victimDirty) begin
          nextState = ST_WBACK;
        end else begin
          nextState = ST_RDADDR;
        end
      end
      ST_WBACK: begin
        memWr     = 1'b1;
        ctl.wbSel = 1'b1;
        if (tick) nextState = ST_RDADDR;
      end
      ST_RDADDR: begin
        memRd = 1'b1;
        if (tick) nextState = ST_RDWAIT;
      end
      ST_RDWAIT: begin
        // memory output register settles one slow cycle later
        if (tick) begin
          ctl.fillLine = 1'b1;
          nextState    = ST_LOOKUP;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      readyQ <= 1'b0;
    end else begin
      state  <= nextState;
      readyQ <= ctl.hitUpdate;
    end
  end

  assign ready = readyQ;

  a_r10_ready_once: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  a_r5_wb_then_read: assert property (@(posedge clk) disable iff (rst)
    $fell(memWr) |-> memRd);

  a_r11_busy_no_take: assert property (@(posedge clk) disable iff (rst)
    (memRd || memWr) |-> !ctl.takeReq);

endmodule

// File: rtl/assoc_cache.sv
module assoc_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int WORD_W  = 16,
  parameter int WORDS   = 4,
  parameter int LINES   = 8,
  parameter int MEM_DIV = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                cpuReq,
  input  logic                                cpuWe,
  input  logic [ADDR_W-1:0]                   cpuAddr,
  input  logic [WORD_W-1:0]                   cpuWdata,
  output logic [WORD_W-1:0]                   cpuRdata,
  output logic                                cpuReady,
  output logic [ADDR_W-$clog2(WORDS)-1:0]     memAddr,
  output logic [WORD_W*WORDS-1:0]             memWdata,
  output logic                                memRd,
  output logic                                memWr,
  input  logic [WORD_W*WORDS-1:0]             memRdata
);
  ctlStrobes_t ctl;
  logic        hit;
  logic        victimDirty;
  logic        tick;

  cache_slowtick #(.MEM_DIV(MEM_DIV)) i_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  cache_control i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .req         (cpuReq),
    .hit         (hit),
    .victimDirty (victimDirty),
    .tick        (tick),
    .ctl         (ctl),
    .ready       (cpuReady),
    .memRd       (memRd),
    .memWr       (memWr)
  );

  cache_datapath #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .WORDS  (WORDS),
    .LINES  (LINES)
  ) i_data (
    .clk         (clk),
    .rst         (rst),
    .ctl         (ctl),
    .reqWe       (cpuWe),
    .reqAddr     (cpuAddr),
    .reqWdata    (cpuWdata),
    .memRdata    (memRdata),
    .hit         (hit),
    .victimDirty (victimDirty),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .rspData     (cpuRdata)
  );

  a_r8_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (memRd && !tick) |=> (memRd && $stable(memAddr)));

  a_r8_wr_hold: assert property (@(posedge clk) disable iff (rst)
    (memWr && !tick) |=> (memWr && $stable(memAddr) && $stable(memWdata)));

  a_r2_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(memRd && memWr));

endmodule

// File: tb/test_assoc_cache.sv
module test_assoc_cache;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  // {we, expHit, expWb, 1'b0, addr[11:0], wdata[15:0]}
  localparam logic [31:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 12'h004, 16'h0000},
    {1'b0, 1'b1, 1'b0, 1'b0, 12'h005, 16'h0000},
    {1'b1, 1'b1, 1'b0, 1'b0, 12'h006, 16'hA111},
    {1'b0, 1'b1, 1'b0, 1'b0, 12'h006, 16'h0000},
    {1'b1, 1'b0, 1'b0, 1'b0, 12'h010, 16'hB222},
    {1'b0, 1'b0, 1'b0, 1'b0, 12'h014, 16'h0000},
    {1'b0, 1'b0, 1'b0, 1'b0, 12'h018, 16'h0000},
    {1'b0, 1'b0, 1'b0, 1'b0, 12'h01C, 16'h0000},
    {1'b0, 1'b0, 1'b0, 1'b0, 12'h020, 16'h0000},
    {1'b0, 1'b0, 1'b0, 1'b0, 12'h024, 16'h0000},
    {1'b0, 1'b0, 1'b0, 1'b0, 12'h028, 16'h0000},
    {1'b0, 1'b0, 1'b1, 1'b0, 12'h02C, 16'h0000},
    {1'b0, 1'b0, 1'b1, 1'b0, 12'h006, 16'h0000},
    {1'b0, 1'b0, 1'b0, 1'b0, 12'h010, 16'h0000},
    {1'b0, 1'b1, 1'b0, 1'b0, 12'h02C, 16'h0000},
    {1'b1, 1'b0, 1'b0, 1'b0, 12'hFFF, 16'hC333},
    {1'b0, 1'b1, 1'b0, 1'b0, 12'hFFF, 16'h0000},
    {1'b0, 1'b1, 1'b0, 1'b0, 12'hFFC, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpuReq = 1'b0;
  logic        cpuWe = 1'b0;
  logic [11:0] cpuAddr = '0;
  logic [15:0] cpuWdata = '0;
  logic [15:0] cpuRdata;
  logic        cpuReady;
  logic [9:0]  memAddr;
  logic [63:0] memWdata;
  logic        memRd;
  logic        memWr;
  logic [63:0] memRdata = '0;

  logic [63:0] mem    [1024];
  logic [15:0] golden [4096];
  logic [2:0]  bcnt = '0;
  int          memWrCnt = 0;
  int          memRdCnt = 0;
  int          testCnt = 0;
  int          failCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assoc_cache i_assoc_cache (
    .clk      (clk),
    .rst      (rst),
    .cpuReq   (cpuReq),
    .cpuWe    (cpuWe),
    .cpuAddr  (cpuAddr),
    .cpuWdata (cpuWdata),
    .cpuRdata (cpuRdata),
    .cpuReady (cpuReady),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memRd    (memRd),
    .memWr    (memWr),
    .memRdata (memRdata)
  );

  // slow memory: acts on every 8th edge after reset release (R8)
  always @(posedge clk) begin
    if (rst) begin
      bcnt <= '0;
    end else begin
      bcnt <= bcnt + 3'd1;
      if (bcnt == 3'd7) begin
        if (memWr) begin
          mem[memAddr] <= memWdata;
          memWrCnt <= memWrCnt + 1;
        end
        if (memRd) begin
          memRdata <= mem[memAddr];
          memRdCnt <= memRdCnt + 1;
        end
      end
    end
  end

  function automatic logic [15:0] initWord(input int a);
    logic [11:0] aa;
    aa = 12'(a);
    return {aa[11:2], aa[1:0], 4'hA};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doReq(input logic we, input logic [11:0] a, input logic [15:0] d,
                       output logic [15:0] rd, output int lat, output int nw, output int nr);
    int w0;
    int r0;
    w0 = memWrCnt;
    r0 = memRdCnt;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = d;
    @(posedge clk);
    @(negedge clk);
    cpuReq = 1'b0;
    lat = 1;
    while (!cpuReady && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    chk(cpuReady, "R3", "ready timeout", 64'(lat), 64'(0));
    rd = cpuRdata;
    @(negedge clk);
    chk(!cpuReady, "R10", "ready longer than one cycle", 64'(cpuReady), 64'(0));
    nw = memWrCnt - w0;
    nr = memRdCnt - r0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    testCnt++;
    failCnt++;
    $display("FAIL R3 watchdog expired actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int lat, nw, nr, readies;
    for (int l = 0; l < 1024; l++)
      mem[l] = {initWord(l*4+3), initWord(l*4+2), initWord(l*4+1), initWord(l*4)};
    for (int a = 0; a < 4096; a++) golden[a] = initWord(a);

    repeat (3) @(negedge clk);
    chk(cpuReady == 1'b0, "R2", "ready in reset", 64'(cpuReady), 64'(0));
    rst = 1'b0;
    @(negedge clk);
    chk(!memRd && !memWr, "R2", "strobes after reset", {62'd0, memRd, memWr}, 64'(0));

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] v;
      v = VECS[i];
      doReq(v[31], v[27:16], v[15:0], rd, lat, nw, nr);
      if (v[31]) golden[v[27:16]] = v[15:0];
      else chk(rd == golden[v[27:16]], "R1", $sformatf("R9 read data vec %0d", i),
               64'(rd), 64'(golden[v[27:16]]));
      chk(nw == int'(v[29]), "R5", $sformatf("R6 write-backs vec %0d", i), 64'(nw), 64'(v[29]));
      chk(nr == (v[30] ? 0 : 1), "R4", $sformatf("R8 R7 refill reads vec %0d", i),
          64'(nr), 64'(v[30] ? 0 : 1));
      if (v[30]) chk(lat == 2, "R3", $sformatf("hit latency vec %0d", i), 64'(lat), 64'(2));
    end

    // written-back contents now in memory
    chk(mem[1][47:32] == 16'hA111, "R5", "victim word in memory", 64'(mem[1][47:32]), 64'hA111);
    chk(mem[4][15:0] == 16'hB222, "R7", "write-miss word in memory", 64'(mem[4][15:0]), 64'hB222);
    chk(mem[4][31:16] == initWord(17), "R7", "neighbour word untouched",
        64'(mem[4][31:16]), 64'(initWord(17)));

    // reset again: all lines invalid, stored tags zero
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int a = 0; a < 4096; a++) golden[a] = mem[a >> 2][(a % 4) * 16 +: 16];
    doReq(1'b0, 12'h000, 16'h0, rd, lat, nw, nr);
    chk(nr == 1, "R2", "invalid line hit on tag 0", 64'(nr), 64'(1));
    chk(rd == golden[0], "R2", "data after reset miss", 64'(rd), 64'(golden[0]));

    // request while a refill is in flight
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = 12'h101;
    @(negedge clk);
    cpuReq = 1'b0;
    repeat (3) @(negedge clk);
    cpuReq = 1'b1; cpuWe = 1'b1; cpuAddr = 12'h101; cpuWdata = 16'hDEAD;
    @(negedge clk);
    cpuReq = 1'b0;
    readies = 0;
    for (int c = 0; c < 60; c++) begin
      if (cpuReady) begin
        readies++;
        chk(cpuRdata == golden[12'h101], "R11", "busy read data", 64'(cpuRdata), 64'(golden[12'h101]));
      end
      @(negedge clk);
    end
    chk(readies == 1, "R11", "ready pulses while busy", 64'(readies), 64'(1));
    doReq(1'b0, 12'h101, 16'h0, rd, lat, nw, nr);
    chk(rd == golden[12'h101], "R11", "stray write ignored", 64'(rd), 64'(golden[12'h101]));
    chk(nr == 0 && lat == 2, "R3", "hit after busy test", 64'(lat), 64'(2));

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule